// File: doc/BRIEF.md
# Multiplexed Parallel Bus Master

This block turns single read or write requests from a local host into cycles on an external parallel bus. The host presents a 16-bit address, 8-bit write data, a direction bit and a device select, and holds a request line high until the block returns a one-cycle acknowledge. Read data comes back with that acknowledge. On the bus side the block drives active-high read, write and chip-select strobes, an address bus, and a shared 8-bit address/data bus. It also drives three address-latch strobes, one for each of the low, high and upper address bytes, and an optional end-of-cycle interrupt.

Configuration inputs control the cycle. They set how many address bytes are placed on the shared data lines before the data phase, and whether an address byte is skipped when its external latch already holds that value. They also set the latch strobe polarity, where the two chip selects appear, whether the data lines keep their last value when idle, and the interrupt mode. A global enable stops all bus activity when it is cleared.

Top module: `pbus_master`

## Requirements
- R1: While `cfg_en` is 0 the block asserts no latch, read, write or chip-select strobe and never acknowledges, even if `host_req` is held high.
- R2: `cfg_admux` = 0 emits no address phase. Settings 1, 2 and 3 emit the low, then high, then upper address phases, using the first 1, 2 or 3 of that list. During each latch strobe, `bus_ad_out` carries that byte: low = address[7:0], high = address[15:8], upper = 8'h00.
- R3: Each address phase lasts two cycles, with its latch strobe active in the first cycle only. The data phase keeps `bus_rd` or `bus_wr` high for exactly two cycles. Counting the cycle after the accepting clock edge as cycle 1, `host_ack` is high in cycle 2N+3, where N is the number of address phases emitted.
- R4: `cfg_al_pol` = 1 makes all three latch strobes active-high (idle 0). `cfg_al_pol` = 0 makes them active-low (idle 1).
- R5: With `cfg_smart` = 1, an address phase is emitted only when its byte differs from the value last loaded into that latch. Phases that are not needed are left out, and the remaining ones keep their relative order.
- R6: After reset, and after `cfg_en` has been 0, every remembered latch value is invalid. The next access therefore emits every configured phase, even in smart mode.
- R7: With `cfg_keep` = 1, the idle bus keeps `bus_ad_oe` high and `bus_ad_out` at the last value driven. With `cfg_keep` = 0, the idle bus has `bus_ad_oe` low.
- R8: `host_sel` = 0 selects device 1 and `host_sel` = 1 selects device 2. The selected chip select is active-high through the address and data phases. `cfg_csmap` 0 drives `bus_cs1`/`bus_cs2`. Setting 1 puts device 2 on `bus_addr[15]` and keeps device 1 on `bus_cs1`. Setting 2 puts device 2 on `bus_addr[15]` and device 1 on `bus_addr[14]`. Setting 3 behaves as 0. Overridden select bits replace the address bits.
- R9: `cfg_irqm` = 1 gives one `irq` pulse in the acknowledge cycle of every access. Every other code gives none.
- R10: `host_ack` is high for exactly one cycle per access. `host_rdata` then holds `bus_ad_in` as sampled on the last cycle of the read strobe.
- R11: During the write strobe, `bus_ad_oe` is 1 and `bus_ad_out` carries the write data. During the read strobe, `bus_ad_oe` is 0. During the data phase, `bus_addr` carries the access address, apart from any chip-select overrides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Global enable |
| cfg_admux | input | 2 | Number of multiplexed address phases (0 to 3) |
| cfg_smart | input | 1 | Skip address phases whose latch would not change |
| cfg_al_pol | input | 1 | Latch strobe polarity, 1 = active-high |
| cfg_csmap | input | 2 | Chip-select placement |
| cfg_keep | input | 1 | Bus keeper enable |
| cfg_irqm | input | 2 | Interrupt mode, 1 = end-of-cycle pulse |
| host_req | input | 1 | Request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | Device select, 0 = device 1, 1 = device 2 |
| host_addr | input | 16 | Access address |
| host_wdata | input | 8 | Write data |
| host_ack | output | 1 | One-cycle acknowledge |
| host_rdata | output | 8 | Read data, valid with acknowledge |
| irq | output | 1 | End-of-cycle interrupt pulse |
| bus_addr | output | 16 | Address pins, with chip-select overrides |
| bus_ad_out | output | 8 | Shared address/data bus, output value |
| bus_ad_oe | output | 1 | Shared bus output enable |
| bus_ad_in | input | 8 | Shared bus input value |
| bus_rd | output | 1 | Read strobe, active-high |
| bus_wr | output | 1 | Write strobe, active-high |
| bus_cs1 | output | 1 | Device 1 chip select, active-high |
| bus_cs2 | output | 1 | Device 2 chip select, active-high |
| bus_al_lo | output | 1 | Low-byte latch strobe |
| bus_al_hi | output | 1 | High-byte latch strobe |
| bus_al_up | output | 1 | Upper-byte latch strobe |

## Verification
The assertions assume the host keeps `host_req` and its request fields steady until the acknowledge. They also assume the configuration inputs stay constant while an access is in flight, so that the two-cycle strobe and single-cycle acknowledge properties are judged against one fixed set of settings. The bench changes configuration only between accesses, while the block is idle. It drops the request in the same idle gap in which it observes the acknowledge. When it tests disable, it clears `cfg_en` only from the idle state.

// File: rtl/pbus_pkg.sv
// Shared types and helpers for the multiplexed parallel bus master.
// Assumes three address latches (low, high, upper) in that priority order.
package pbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } pbus_state_e;

    localparam int NUM_LATCH = 3;

    // Lowest pending latch index; low byte first, upper byte last.
    function automatic logic [1:0] first_pending(input logic [NUM_LATCH-1:0] mask);
        if (mask[0])      return 2'd0;
        else if (mask[1]) return 2'd1;
        else              return 2'd2;
    endfunction

endpackage

// File: rtl/pbus_track.sv
// Remembers the byte last loaded into each external address latch and decides
// which address phases the next access needs. Assumes cfg values are stable
// at the accepting edge; clearing enable invalidates every remembered byte.
module pbus_track
    import pbus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 smart,
    input  logic [1:0]           nphase,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 accept,
    output logic [NUM_LATCH-1:0] need
);

    localparam int EXT_W = NUM_LATCH * DATA_W;

    logic [EXT_W-1:0] ext;
    assign ext = EXT_W'(addr);

    genvar g;
    generate
        for (g = 0; g < NUM_LATCH; g++) begin : g_latch
            logic [DATA_W-1:0] last_q;
            logic              vld_q;
            logic              in_use;
            logic [DATA_W-1:0] byte_now;

            assign in_use   = (nphase > 2'(g));
            assign byte_now = ext[g*DATA_W +: DATA_W];
            assign need[g]  = in_use && (!smart || !vld_q || (last_q != byte_now));

            // Record the byte each time this latch is loaded; forget on reset or disable.
            always_ff @(posedge clk) begin
                if (!rst_n || !en) begin
                    vld_q  <= 1'b0;
                    last_q <= '0;
                end else if (accept && need[g]) begin
                    vld_q  <= 1'b1;
                    last_q <= byte_now;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pbus_seq.sv
// Cycle sequencer: accepts a host request, walks the needed address phases in
// low/high/upper order (two cycles each, latch strobe in the first), runs a
// two-cycle data phase, then acknowledges for one cycle. Assumes the host holds
// its request fields until the acknowledge.
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 req,
    input  logic                 we,
    input  logic                 sel,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_LATCH-1:0] need,
    input  logic [DATA_W-1:0]    ad_in,
    output logic                 accept,
    output logic [NUM_LATCH-1:0] al_act,
    output logic                 rd_act,
    output logic                 wr_act,
    output logic                 cs1_act,
    output logic                 cs2_act,
    output logic                 ad_drive,
    output logic [DATA_W-1:0]    ad_val,
    output logic                 ack,
    output logic [DATA_W-1:0]    rdata,
    output logic [ADDR_W-1:0]    cur_addr
);

    localparam int EXT_W = NUM_LATCH * DATA_W;

    pbus_state_e          st;
    logic                 sub;
    logic [1:0]           cur;
    logic [NUM_LATCH-1:0] rem;
    logic [NUM_LATCH-1:0] rem_next;
    logic                 we_q;
    logic                 sel_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    wdata_q;
    logic [EXT_W-1:0]     ext_q;
    logic                 busy;

    assign accept   = en && (st == ST_IDLE) && req;
    assign rem_next = rem & ~(NUM_LATCH'(1) << cur);
    assign ext_q    = EXT_W'(addr_q);
    assign busy     = (st == ST_ADDR) || (st == ST_DATA);

    // Phase state machine; disable drops any access in flight.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st  <= ST_IDLE;
            sub <= 1'b0;
            cur <= 2'd0;
            rem <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req) begin
                        sub <= 1'b0;
                        rem <= need;
                        cur <= first_pending(need);
                        st  <= (need != '0) ? ST_ADDR : ST_DATA;
                    end
                end
                ST_ADDR: begin
                    if (!sub) begin
                        sub <= 1'b1;
                    end else begin
                        sub <= 1'b0;
                        rem <= rem_next;
                        if (rem_next != '0) cur <= first_pending(rem_next);
                        else                st  <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (!sub) begin
                        sub <= 1'b1;
                    end else begin
                        sub <= 1'b0;
                        st  <= ST_DONE;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Capture the request fields at the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            sel_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            we_q    <= we;
            sel_q   <= sel;
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    // Sample read data on the last cycle of the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en && (st == ST_DATA) && sub && !we_q) begin
            rdata <= ad_in;
        end
    end

    // Decode strobes and bus contents from the current phase.
    always_comb begin
        al_act   = (st == ST_ADDR && !sub) ? (NUM_LATCH'(1) << cur) : '0;
        rd_act   = (st == ST_DATA) && !we_q;
        wr_act   = (st == ST_DATA) && we_q;
        cs1_act  = busy && !sel_q;
        cs2_act  = busy && sel_q;
        ad_drive = (st == ST_ADDR) || ((st == ST_DATA) && we_q);
        ad_val   = (st == ST_ADDR) ? ext_q[cur*DATA_W +: DATA_W] : wdata_q;
        ack      = en && (st == ST_DONE);
        cur_addr = addr_q;
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n || !en)
        ack |=> !ack); // R10
    AST_LATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (|al_act) |=> !(|al_act)); // R3
    AST_WR_TWO_CYC: assert property (@(posedge clk) disable iff (!rst_n || !en)
        $rose(wr_act) |=> wr_act); // R3
    AST_WR_ENDS: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (wr_act && $past(wr_act)) |=> !wr_act); // R3
    AST_RD_TWO_CYC: assert property (@(posedge clk) disable iff (!rst_n || !en)
        $rose(rd_act) |=> rd_act); // R3

endmodule

// File: rtl/pbus_pins.sv
// Pin stage: applies latch polarity, chip-select placement, enable gating,
// bus keeper and interrupt mode to the sequencer's internal strobes.
// Assumes ADDR_W is at least 2 so two address bits can carry chip selects.
module pbus_pins
    import pbus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 al_pol,
    input  logic [1:0]           csmap,
    input  logic                 keep,
    input  logic [1:0]           irqm,
    input  logic [NUM_LATCH-1:0] al_act,
    input  logic                 rd_act,
    input  logic                 wr_act,
    input  logic                 cs1_act,
    input  logic                 cs2_act,
    input  logic                 ad_drive,
    input  logic [DATA_W-1:0]    ad_val,
    input  logic                 ack,
    input  logic [ADDR_W-1:0]    cur_addr,
    output logic                 bus_al_lo,
    output logic                 bus_al_hi,
    output logic                 bus_al_up,
    output logic                 bus_rd,
    output logic                 bus_wr,
    output logic                 bus_cs1,
    output logic                 bus_cs2,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [DATA_W-1:0]    bus_ad_out,
    output logic                 bus_ad_oe,
    output logic                 irq
);

    localparam logic [1:0] MAP_PINS  = 2'd0;
    localparam logic [1:0] MAP_A15   = 2'd1;
    localparam logic [1:0] MAP_A1514 = 2'd2;

    logic [NUM_LATCH-1:0] al_on;
    logic [1:0]           map_eff;
    logic                 c1;
    logic                 c2;
    logic [DATA_W-1:0]    held_q;
    logic                 drive_now;

    assign al_on     = en ? al_act : '0;
    assign map_eff   = (csmap == 2'd3) ? MAP_PINS : csmap;
    assign c1        = en && cs1_act;
    assign c2        = en && cs2_act;
    assign drive_now = en && ad_drive;

    // Latch strobes at the configured polarity.
    always_comb begin
        bus_al_lo = al_pol ? al_on[0] : ~al_on[0];
        bus_al_hi = al_pol ? al_on[1] : ~al_on[1];
        bus_al_up = al_pol ? al_on[2] : ~al_on[2];
    end

    // Read/write strobes and interrupt, gated by enable.
    always_comb begin
        bus_rd = en && rd_act;
        bus_wr = en && wr_act;
        irq    = ack && (irqm == 2'd1);
    end

    // Chip-select placement on dedicated pins or top address bits.
    always_comb begin
        bus_addr = cur_addr;
        bus_cs1  = 1'b0;
        bus_cs2  = 1'b0;
        case (map_eff)
            MAP_A15: begin
                bus_cs1            = c1;
                bus_addr[ADDR_W-1] = c2;
            end
            MAP_A1514: begin
                bus_addr[ADDR_W-1] = c2;
                bus_addr[ADDR_W-2] = c1;
            end
            default: begin
                bus_cs1 = c1;
                bus_cs2 = c2;
            end
        endcase
    end

    // Keeper register: last value placed on the shared bus.
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= '0;
        else if (drive_now) held_q <= ad_val;
    end

    // Shared bus drive: active value, kept value, or released.
    always_comb begin
        if (drive_now) begin
            bus_ad_oe  = 1'b1;
            bus_ad_out = ad_val;
        end else if (keep && !(en && rd_act)) begin
            bus_ad_oe  = 1'b1;
            bus_ad_out = held_q;
        end else begin
            bus_ad_oe  = 1'b0;
            bus_ad_out = '0;
        end
    end

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!bus_rd && !bus_wr && !bus_cs1 && !bus_cs2 && !ack &&
                 bus_al_lo == !al_pol && bus_al_hi == !al_pol && bus_al_up == !al_pol)); // R1
    AST_CS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs1 && bus_cs2)); // R8
    AST_RD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> !bus_ad_oe); // R11
    AST_IRQ_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ack); // R9
    AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> bus_ad_oe); // R11

endmodule

// File: rtl/pbus_master.sv
// Top of the multiplexed parallel bus master: ties the latch tracker, the
// phase sequencer and the pin stage together. One access at a time; host
// holds its request until the acknowledge.
module pbus_master
    import pbus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [1:0]        cfg_admux,
    input  logic              cfg_smart,
    input  logic              cfg_al_pol,
    input  logic [1:0]        cfg_csmap,
    input  logic              cfg_keep,
    input  logic [1:0]        cfg_irqm,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_cs1,
    output logic              bus_cs2,
    output logic              bus_al_lo,
    output logic              bus_al_hi,
    output logic              bus_al_up
);

    logic [NUM_LATCH-1:0] need;
    logic                 accept;
    logic [NUM_LATCH-1:0] al_act;
    logic                 rd_act;
    logic                 wr_act;
    logic                 cs1_act;
    logic                 cs2_act;
    logic                 ad_drive;
    logic [DATA_W-1:0]    ad_val;
    logic                 ack;
    logic [ADDR_W-1:0]    cur_addr;

    assign host_ack = ack;

    pbus_track #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg_en),
        .smart  (cfg_smart),
        .nphase (cfg_admux),
        .addr   (host_addr),
        .accept (accept),
        .need   (need)
    );

    pbus_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_en),
        .req      (host_req),
        .we       (host_we),
        .sel      (host_sel),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .need     (need),
        .ad_in    (bus_ad_in),
        .accept   (accept),
        .al_act   (al_act),
        .rd_act   (rd_act),
        .wr_act   (wr_act),
        .cs1_act  (cs1_act),
        .cs2_act  (cs2_act),
        .ad_drive (ad_drive),
        .ad_val   (ad_val),
        .ack      (ack),
        .rdata    (host_rdata),
        .cur_addr (cur_addr)
    );

    pbus_pins #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg_en),
        .al_pol     (cfg_al_pol),
        .csmap      (cfg_csmap),
        .keep       (cfg_keep),
        .irqm       (cfg_irqm),
        .al_act     (al_act),
        .rd_act     (rd_act),
        .wr_act     (wr_act),
        .cs1_act    (cs1_act),
        .cs2_act    (cs2_act),
        .ad_drive   (ad_drive),
        .ad_val     (ad_val),
        .ack        (ack),
        .cur_addr   (cur_addr),
        .bus_al_lo  (bus_al_lo),
        .bus_al_hi  (bus_al_hi),
        .bus_al_up  (bus_al_up),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_cs1    (bus_cs1),
        .bus_cs2    (bus_cs2),
        .bus_addr   (bus_addr),
        .bus_ad_out (bus_ad_out),
        .bus_ad_oe  (bus_ad_oe),
        .irq        (irq)
    );

endmodule

// File: tb/pbus_master_tb.sv
// Directed bench for pbus_master: one task per scenario, each checking itself.
module pbus_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b1;
    logic [1:0]  cfg_admux = 2'd0;
    logic        cfg_smart = 1'b0;
    logic        cfg_al_pol = 1'b1;
    logic [1:0]  cfg_csmap = 2'd0;
    logic        cfg_keep = 1'b0;
    logic [1:0]  cfg_irqm = 2'd0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ack;
    logic [7:0]  host_rdata;
    logic        irq;
    logic [15:0] bus_addr;
    logic [7:0]  bus_ad_out;
    logic        bus_ad_oe;
    logic [7:0]  bus_ad_in = '0;
    logic        bus_rd, bus_wr, bus_cs1, bus_cs2;
    logic        bus_al_lo, bus_al_hi, bus_al_up;

    pbus_master u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_admux(cfg_admux),
        .cfg_smart(cfg_smart), .cfg_al_pol(cfg_al_pol), .cfg_csmap(cfg_csmap),
        .cfg_keep(cfg_keep), .cfg_irqm(cfg_irqm), .host_req(host_req),
        .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
        .irq(irq), .bus_addr(bus_addr), .bus_ad_out(bus_ad_out),
        .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_cs1(bus_cs1), .bus_cs2(bus_cs2),
        .bus_al_lo(bus_al_lo), .bus_al_hi(bus_al_hi), .bus_al_up(bus_al_up)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_total = 0;
    bit finished = 0;

    // Bench model of remembered latch contents
    logic       mv[3];
    logic [7:0] ml[3];

    // Per-access observations
    int         n_al, wr_cyc, rd_cyc, ack_cyc, width_bad, irq_cnt;
    int         seq_code[8];
    logic [7:0] seq_val[8];
    logic [7:0] wr_ad, got_rd;
    logic [15:0] data_addr;
    logic       saw_cs1, saw_cs2, saw_a15, saw_a14, rd_oe_seen, post_ack;
    logic       post_oe;
    logic [7:0] post_out;

    // Watchdog: an overrun counts as a failure and still reports.
    always @(negedge clk) begin
        cyc_total++;
        if (cyc_total > 100000 && !finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cyc_total);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dev_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic forget_model();
        for (int i = 0; i < 3; i++) begin
            mv[i] = 1'b0;
            ml[i] = 8'h00;
        end
    endtask

    // Run one access and record what appears on the bus each cycle.
    task automatic do_xfer(input logic we, input logic sel, input logic [15:0] a, input logic [7:0] wd);
        logic prev_al;
        bit   done;
        n_al = 0; wr_cyc = 0; rd_cyc = 0; ack_cyc = 0; width_bad = 0; irq_cnt = 0;
        saw_cs1 = 0; saw_cs2 = 0; saw_a15 = 0; saw_a14 = 0; rd_oe_seen = 0;
        wr_ad = '0; got_rd = '0; data_addr = '0; prev_al = 0; done = 0;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_sel = sel; host_addr = a; host_wdata = wd;
        bus_ad_in = dev_val(a);
        for (int c = 1; c <= 64 && !done; c++) begin
            logic lo, hi, up;
            @(negedge clk);
            lo = (bus_al_lo == cfg_al_pol);
            hi = (bus_al_hi == cfg_al_pol);
            up = (bus_al_up == cfg_al_pol);
            if ((lo || hi || up) && n_al < 8) begin
                seq_code[n_al] = lo ? 1 : (hi ? 2 : 3);
                seq_val[n_al]  = bus_ad_out;
                n_al++;
                if (prev_al) width_bad++;
            end
            prev_al = lo || hi || up;
            if (bus_wr) begin wr_cyc++; wr_ad = bus_ad_out; data_addr = bus_addr; end
            if (bus_rd) begin rd_cyc++; data_addr = bus_addr; if (bus_ad_oe) rd_oe_seen = 1; end
            if (bus_cs1) saw_cs1 = 1;
            if (bus_cs2) saw_cs2 = 1;
            if ((bus_rd || bus_wr) && bus_addr[15]) saw_a15 = 1;
            if ((bus_rd || bus_wr) && bus_addr[14]) saw_a14 = 1;
            if (irq) irq_cnt++;
            if (host_ack) begin
                ack_cyc = c;
                got_rd = host_rdata;
                done = 1;
            end
        end
        host_req = 1'b0;
        if (!done) chk(0, "R10 ack timeout", 0, 1);
        @(negedge clk);
        post_ack = host_ack;
        post_oe  = bus_ad_oe;
        post_out = bus_ad_out;
        if (irq) irq_cnt++;
    endtask

    // Access with full checking against the bench model.
    task automatic xfer_check(input logic we, input logic sel, input logic [15:0] a, input logic [7:0] wd);
        int         exp_n;
        int         codes[3];
        logic [7:0] vals[3];
        logic [23:0] ext;
        ext = {8'h00, a};
        exp_n = 0;
        for (int i = 0; i < 3; i++) begin
            if (i < int'(cfg_admux) &&
                (!cfg_smart || !mv[i] || ml[i] != ext[i*8 +: 8])) begin
                codes[exp_n] = i + 1;
                vals[exp_n]  = ext[i*8 +: 8];
                exp_n++;
                mv[i] = 1'b1;
                ml[i] = ext[i*8 +: 8];
            end
        end
        do_xfer(we, sel, a, wd);
        chk(n_al == exp_n, "R2/R5 phase count", 32'(n_al), 32'(exp_n));
        for (int i = 0; i < exp_n && i < n_al; i++) begin
            chk(seq_code[i] == codes[i], "R2 phase order", 32'(seq_code[i]), 32'(codes[i]));
            chk(seq_val[i] == vals[i], "R2 phase byte", 32'(seq_val[i]), 32'(vals[i]));
        end
        chk(width_bad == 0, "R3 latch strobe width", 32'(width_bad), 0);
        chk(ack_cyc == 2*exp_n + 3, "R3 ack cycle", 32'(ack_cyc), 32'(2*exp_n + 3));
        if (we) begin
            chk(wr_cyc == 2, "R3 write strobe cycles", 32'(wr_cyc), 2);
            chk(wr_ad == wd, "R11 write data on bus", 32'(wr_ad), 32'(wd));
        end else begin
            chk(rd_cyc == 2, "R3 read strobe cycles", 32'(rd_cyc), 2);
            chk(got_rd == dev_val(a), "R10 read data", 32'(got_rd), 32'(dev_val(a)));
            chk(!rd_oe_seen, "R11 bus released on read", 32'(rd_oe_seen), 0);
        end
        chk(!post_ack, "R10 ack single cycle", 32'(post_ack), 0);
        chk(irq_cnt == ((cfg_irqm == 2'd1) ? 1 : 0), "R9 irq count", 32'(irq_cnt),
            (cfg_irqm == 2'd1) ? 1 : 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!host_ack, "R10 reset ack", 32'(host_ack), 0);
        chk(!bus_rd && !bus_wr, "R3 reset strobes", {bus_rd, bus_wr}, 0);
        chk({bus_al_lo, bus_al_hi, bus_al_up} == 3'b000, "R4 reset latch idle high-pol",
            {bus_al_lo, bus_al_hi, bus_al_up}, 0);
        chk(!bus_ad_oe, "R7 reset bus released", 32'(bus_ad_oe), 0);
        chk(!irq, "R9 reset irq", 32'(irq), 0);
    endtask

    task automatic t_separate();
        cfg_admux = 2'd0; cfg_csmap = 2'd0;
        xfer_check(1'b1, 1'b0, 16'h2A5B, 8'hC3);
        chk(data_addr == 16'h2A5B, "R11 address pins", 32'(data_addr), 32'h2A5B);
        xfer_check(1'b0, 1'b0, 16'h1357, 8'h00);
        chk(data_addr == 16'h1357, "R11 address pins read", 32'(data_addr), 32'h1357);
    endtask

    task automatic t_mux();
        cfg_smart = 1'b0;
        for (int m = 1; m <= 3; m++) begin
            cfg_admux = 2'(m);
            xfer_check(1'b1, 1'b0, 16'h3C96 + 16'(m), 8'h10 + 8'(m));
            xfer_check(1'b0, 1'b1, 16'h0F0F + 16'(m), 8'h00);
        end
    endtask

    task automatic t_polarity();
        cfg_al_pol = 1'b0; cfg_admux = 2'd2;
        @(negedge clk);
        chk({bus_al_lo, bus_al_hi, bus_al_up} == 3'b111, "R4 low-pol idle level",
            {bus_al_lo, bus_al_hi, bus_al_up}, 3'b111);
        xfer_check(1'b1, 1'b0, 16'h4455, 8'h66);
        cfg_al_pol = 1'b1;
    endtask

    task automatic t_smart();
        cfg_smart = 1'b1; cfg_admux = 2'd3;
        xfer_check(1'b1, 1'b0, 16'h1122, 8'h01);
        xfer_check(1'b1, 1'b0, 16'h1122, 8'h02);
        chk(n_al == 0, "R5 repeat address skips all", 32'(n_al), 0);
        xfer_check(1'b0, 1'b0, 16'h9922, 8'h00);
        chk(n_al == 1 && seq_code[0] == 2, "R5 only high phase", 32'(seq_code[0]), 2);
        xfer_check(1'b1, 1'b0, 16'h9977, 8'h03);
        chk(n_al == 1 && seq_code[0] == 1, "R5 only low phase", 32'(seq_code[0]), 1);
    endtask

    task automatic t_disable_reenable();
        int bad;
        bad = 0;
        @(negedge clk);
        cfg_en = 1'b0;
        host_req = 1'b1; host_we = 1'b1; host_addr = 16'h9977;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (host_ack || bus_wr || bus_rd || bus_cs1 || bus_cs2 ||
                bus_al_lo || bus_al_hi || bus_al_up) bad++;
        end
        chk(bad == 0, "R1 disabled quiet", 32'(bad), 0);
        host_req = 1'b0;
        forget_model();
        cfg_en = 1'b1;
        xfer_check(1'b1, 1'b0, 16'h9977, 8'h04);
        chk(n_al == 3, "R6 all phases after re-enable", 32'(n_al), 3);
        cfg_smart = 1'b0;
    endtask

    task automatic t_keeper();
        cfg_admux = 2'd0;
        cfg_keep = 1'b1;
        xfer_check(1'b1, 1'b0, 16'h0101, 8'hA7);
        chk(post_oe && post_out == 8'hA7, "R7 keeper holds value", {post_oe, post_out}, {1'b1, 8'hA7});
        xfer_check(1'b0, 1'b0, 16'h0202, 8'h00);
        cfg_keep = 1'b0;
        xfer_check(1'b1, 1'b0, 16'h0303, 8'h5E);
        chk(!post_oe, "R7 released without keeper", 32'(post_oe), 0);
    endtask

    task automatic t_cs();
        cfg_admux = 2'd0;
        cfg_csmap = 2'd0;
        xfer_check(1'b1, 1'b0, 16'h1234, 8'h11);
        chk(saw_cs1 && !saw_cs2, "R8 map0 device1", {saw_cs1, saw_cs2}, 2'b10);
        xfer_check(1'b1, 1'b1, 16'h1234, 8'h12);
        chk(!saw_cs1 && saw_cs2, "R8 map0 device2", {saw_cs1, saw_cs2}, 2'b01);
        cfg_csmap = 2'd1;
        xfer_check(1'b1, 1'b1, 16'h1234, 8'h13);
        chk(saw_a15 && !saw_cs2, "R8 map1 device2 on a15", {saw_a15, saw_cs2}, 2'b10);
        xfer_check(1'b0, 1'b0, 16'h1234, 8'h00);
        chk(saw_cs1 && !saw_a15, "R8 map1 device1 pin", {saw_cs1, saw_a15}, 2'b10);
        cfg_csmap = 2'd2;
        xfer_check(1'b1, 1'b0, 16'h1234, 8'h14);
        chk(saw_a14 && !saw_cs1 && !saw_a15, "R8 map2 device1 on a14",
            {saw_a14, saw_cs1, saw_a15}, 3'b100);
        xfer_check(1'b1, 1'b1, 16'h1234, 8'h15);
        chk(saw_a15 && !saw_cs2, "R8 map2 device2 on a15", {saw_a15, saw_cs2}, 2'b10);
        cfg_csmap = 2'd3;
        xfer_check(1'b1, 1'b1, 16'h1234, 8'h16);
        chk(saw_cs2 && !saw_a15, "R8 map3 as map0", {saw_cs2, saw_a15}, 2'b10);
        cfg_csmap = 2'd0;
    endtask

    task automatic t_irq();
        cfg_admux = 2'd1;
        cfg_irqm = 2'd1;
        xfer_check(1'b1, 1'b0, 16'h7788, 8'h21);
        xfer_check(1'b0, 1'b0, 16'h7789, 8'h00);
        cfg_irqm = 2'd3;
        xfer_check(1'b1, 1'b0, 16'h778A, 8'h22);
        cfg_irqm = 2'd2;
        xfer_check(1'b0, 1'b0, 16'h778B, 8'h00);
        cfg_irqm = 2'd0;
        xfer_check(1'b1, 1'b0, 16'h778C, 8'h23);
    endtask

    initial begin
        forget_model();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_separate();
        t_mux();
        t_polarity();
        t_smart();
        t_disable_reenable();
        t_keeper();
        t_cs();
        t_irq();
        repeat (3) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule